// File: doc/BRIEF.md
# D-PHY Lane Start/End-of-Transmission Sequencer

This block sits on the transmit side of a serial display link and walks one clock lane and one data lane through the low-power and high-speed line states. Every phase of the entry and exit sequences is timed in byte-clock cycles. Each phase length comes from a one-byte field of three configuration words. A request with a burst length starts a transfer. The burst length models the payload as a number of byte cycles spent in the high-speed state. A single ready flag shows when the block can accept the next request.

The clock lane goes first. It drives LP-01, then LP-00 for its prepare time, then runs HS clocking for its zero time and then for a post time. Only after that does the data lane leave LP-11. The data lane then drives LP-01, LP-00 for its prepare time, HS-0 for its zero time, the payload, and the HS trail. Afterwards it stays in LP-11 for the exit time. A mode input decides whether the clock lane stays in HS after the burst, as in continuous-clock video mode, or runs its own trail and drops back to LP-11. When the clock lane is still in HS, the next request skips the clock-lane entry sequence.

Top module: `dphy_lane_seq`

## Requirements
- R1: After reset both lanes show LP-11 (line code 2'b11, where bit 1 is the positive wire and bit 0 the negative wire), both HS enables are low, payload is low and ready is high.
- R2: From the clock lane in LP-11, an accepted request drives the clock lane through three phases. LP-01 (2'b01) lasts cfg_w0[15:8] cycles. LP-00 (2'b00) with HS off lasts cfg_w1[31:24] cycles. HS clocking (LP code 2'b00, clk_hs_en high) then runs for cfg_w1[23:16] + cfg_w1[15:8] cycles before the data lane moves. The first phase shows on the outputs in the cycle after the edge that accepts the request.
- R3: The data lane never leaves LP-11 while the clock lane is out of HS.
- R4: The data lane runs four phases in order. LP-01 lasts cfg_w0[15:8] cycles. LP-00 with HS off lasts cfg_w2[7:0] cycles. HS-0 (dat_hs_en high, dat_pay low) lasts cfg_w2[15:8] cycles. Payload (dat_pay high) lasts burst_len cycles. LP-00 is never entered directly from LP-11.
- R5: After the payload, the data lane holds the HS trail (dat_hs_en high, dat_pay low) for cfg_w2[23:16] cycles. It then sits in LP-11 for cfg_w0[7:0] cycles, and ready rises in the next cycle.
- R6: A field or burst length of zero lasts exactly one cycle, so no phase is ever skipped.
- R7: With keep_clk low at the request, the clock lane runs its HS trail for cfg_w1[7:0] cycles after the data trail and is in LP-11 during the exit phase. With keep_clk high, the clock lane stays in HS, and the next request starts directly with the data-lane LP-01.
- R8: The configuration words, burst_len and keep_clk are captured only when a request is accepted while ready is high. Changes made while busy have no effect on the running transfer.
- R9: A request raised while ready is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_w0 | input | 32 | Exit time [7:0], LP-01 time [15:8] |
| cfg_w1 | input | 32 | Clock trail [7:0], post [15:8], clock zero [23:16], clock prepare [31:24] |
| cfg_w2 | input | 32 | Data prepare [7:0], data zero [15:8], data trail [23:16] |
| keep_clk | input | 1 | Leave clock lane in HS after the burst |
| burst_len | input | LEN_W | Payload length in byte cycles |
| req | input | 1 | Transfer request, taken while ready is high |
| ready | output | 1 | Idle in LP-11 and able to accept a request |
| clk_lp | output | 2 | Clock-lane LP line code |
| clk_hs_en | output | 1 | Clock-lane HS driver enable |
| dat_lp | output | 2 | Data-lane LP line code |
| dat_hs_en | output | 1 | Data-lane HS driver enable |
| dat_pay | output | 1 | Data lane carrying payload |

## Verification
The properties assume reset is asserted at start-up and that the three configuration words are free to change at any time, including mid-sequence. They place no restriction on how req behaves while the block is busy. The stimulus does exploit that freedom: during one transfer it rewrites every configuration word and the burst length and holds req high for several busy cycles. Because it drops req before the transfer ends, exactly one transfer runs. It also drives all-zero fields and a clock lane left in HS from a previous burst.

// File: rtl/dphy_lane_seq.sv
module dphy_lane_seq #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      cfg_w0,
  input  logic [31:0]      cfg_w1,
  input  logic [31:0]      cfg_w2,
  input  logic             keep_clk,
  input  logic [LEN_W-1:0] burst_len,
  input  logic             req,
  output logic             ready,
  output logic [1:0]       clk_lp,
  output logic             clk_hs_en,
  output logic [1:0]       dat_lp,
  output logic             dat_hs_en,
  output logic             dat_pay
);
  localparam int CW = (LEN_W > 8) ? LEN_W : 8;

  typedef enum logic [3:0] {
    S_IDLE, S_CLP01, S_CPREP, S_CZERO, S_CPOST,
    S_DLP01, S_DPREP, S_DZERO, S_DPAY, S_DTRAIL,
    S_CTRAIL, S_EXIT
  } st_t;

  st_t st, nxt;
  logic [CW-1:0] cnt, dur;
  logic [31:0] w0, w1, w2;
  logic [LEN_W-1:0] len_q;
  logic keep_q, clk_on;

  wire idle = (st == S_IDLE);
  wire [31:0] u0 = idle ? cfg_w0 : w0;
  wire [31:0] u1 = idle ? cfg_w1 : w1;
  wire [31:0] u2 = idle ? cfg_w2 : w2;
  wire [LEN_W-1:0] ulen = idle ? burst_len : len_q;

  always_comb begin
    case (st)
      S_IDLE:   nxt = clk_on ? S_DLP01 : S_CLP01;
      S_CLP01:  nxt = S_CPREP;
      S_CPREP:  nxt = S_CZERO;
      S_CZERO:  nxt = S_CPOST;
      S_CPOST:  nxt = S_DLP01;
      S_DLP01:  nxt = S_DPREP;
      S_DPREP:  nxt = S_DZERO;
      S_DZERO:  nxt = S_DPAY;
      S_DPAY:   nxt = S_DTRAIL;
      S_DTRAIL: nxt = keep_q ? S_EXIT : S_CTRAIL;
      S_CTRAIL: nxt = S_EXIT;
      default:  nxt = S_IDLE;
    endcase
  end

  always_comb begin
    case (nxt)
      S_CLP01, S_DLP01: dur = CW'(u0[15:8]);
      S_CPREP:  dur = CW'(u1[31:24]);
      S_CZERO:  dur = CW'(u1[23:16]);
      S_CPOST:  dur = CW'(u1[15:8]);
      S_DPREP:  dur = CW'(u2[7:0]);
      S_DZERO:  dur = CW'(u2[15:8]);
      S_DPAY:   dur = CW'(ulen);
      S_DTRAIL: dur = CW'(u2[23:16]);
      S_CTRAIL: dur = CW'(u1[7:0]);
      S_EXIT:   dur = CW'(u0[7:0]);
      default:  dur = '0;
    endcase
  end

  wire [CW-1:0] load = (dur == '0) ? '0 : dur - 1'b1;
  wire step = idle ? req : (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      w0     <= '0;
      w1     <= '0;
      w2     <= '0;
      len_q  <= '0;
      keep_q <= 1'b0;
      clk_on <= 1'b0;
    end else begin
      if (idle && req) begin
        w0     <= cfg_w0;
        w1     <= cfg_w1;
        w2     <= cfg_w2;
        len_q  <= burst_len;
        keep_q <= keep_clk;
      end
      if (step) begin
        st  <= nxt;
        cnt <= load;
        if (st == S_CPREP)  clk_on <= 1'b1;
        if (st == S_CTRAIL) clk_on <= 1'b0;
      end else if (!idle) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  assign ready     = idle;
  assign clk_hs_en = clk_on;
  assign clk_lp    = (st == S_CLP01) ? 2'b01 :
                     ((st == S_CPREP) || clk_on) ? 2'b00 : 2'b11;
  assign dat_lp    = (st == S_DLP01) ? 2'b01 :
                     (st inside {S_DPREP, S_DZERO, S_DPAY, S_DTRAIL}) ? 2'b00 : 2'b11;
  assign dat_hs_en = st inside {S_DZERO, S_DPAY, S_DTRAIL};
  assign dat_pay   = (st == S_DPAY);
endmodule

// File: rtl/dphy_lane_seq_chk.sv
module dphy_lane_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic [1:0] clk_lp,
  input logic       clk_hs_en,
  input logic [1:0] dat_lp,
  input logic       dat_hs_en,
  input logic       dat_pay
);
  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (dat_lp == 2'b11) && !dat_hs_en && !dat_pay);

  assert_clk_lp00_after_lp01_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_lp == 2'b00) |-> ($past(clk_lp) != 2'b11));

  assert_clock_before_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_lp != 2'b11) |-> clk_hs_en);

  assert_payload_in_hs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dat_pay |-> dat_hs_en && (dat_lp == 2'b00));

  assert_dat_lp00_after_lp01_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_lp == 2'b00) |-> ($past(dat_lp) != 2'b11));

  assert_ready_from_lp11_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(dat_lp) == 2'b11) && !$past(dat_hs_en));

  assert_hs_lines_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_hs_en |-> (clk_lp == 2'b00));
endmodule

bind dphy_lane_seq dphy_lane_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .clk_lp(clk_lp),
  .clk_hs_en(clk_hs_en), .dat_lp(dat_lp), .dat_hs_en(dat_hs_en), .dat_pay(dat_pay)
);

// File: tb/sim_dphy_lane_seq.sv
module sim_dphy_lane_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] cfg_w0 = '0, cfg_w1 = '0, cfg_w2 = '0;
  logic keep_clk = 1'b0, req = 1'b0;
  logic [15:0] burst_len = '0;
  logic ready, clk_hs_en, dat_hs_en, dat_pay;
  logic [1:0] clk_lp, dat_lp;
  int checks = 0, errors = 0;
  bit clk_on_tb = 1'b0;

  always #5 clk = ~clk;

  dphy_lane_seq u0 (.clk(clk), .rst_n(rst_n), .cfg_w0(cfg_w0), .cfg_w1(cfg_w1),
    .cfg_w2(cfg_w2), .keep_clk(keep_clk), .burst_len(burst_len), .req(req),
    .ready(ready), .clk_lp(clk_lp), .clk_hs_en(clk_hs_en), .dat_lp(dat_lp),
    .dat_hs_en(dat_hs_en), .dat_pay(dat_pay));

  // {w0, w1, w2, len, keep}
  localparam logic [112:0] VEC [4] = '{
    {32'h00000306, 32'h03110A04, 32'h00040A03, 16'd8, 1'b0},
    {32'h00000305, 32'h020E0A03, 32'h00030605, 16'd5, 1'b0},
    {32'h00000102, 32'h01020103, 32'h00020301, 16'd3, 1'b1},
    {32'h00000204, 32'h02030204, 32'h00030202, 16'd4, 1'b0}
  };

  logic [6:0] seg_pat [12];
  int seg_len [12];
  int nseg;

  function automatic int fix(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic logic [6:0] obs();
    return {clk_lp, clk_hs_en, dat_lp, dat_hs_en, dat_pay};
  endfunction

  task automatic push(input logic [6:0] p, input int n);
    seg_pat[nseg] = p;
    seg_len[nseg] = n;
    nseg++;
  endtask

  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                     input logic [15:0] n, input bit k, input string tag, input bit mutate);
    logic [6:0] idle_pat;
    int cyc = 0;
    nseg = 0;
    if (!clk_on_tb) begin
      push(7'b01_0_11_0_0, fix(a[15:8]));                       // R2 LP-01
      push(7'b00_0_11_0_0, fix(b[31:24]));                      // R2 prepare
      push(7'b00_1_11_0_0, fix(b[23:16]) + fix(b[15:8]));       // R2 zero+post, R3
    end
    push(7'b00_1_01_0_0, fix(a[15:8]));                         // R4 LP-01
    push(7'b00_1_00_0_0, fix(c[7:0]));                          // R4 prepare
    push(7'b00_1_00_1_0, fix(c[15:8]));                         // R4 HS-0
    push(7'b00_1_00_1_1, fix(n));                               // R4 payload
    push(7'b00_1_00_1_0, fix(c[23:16]));                        // R5 trail
    if (!k) push(7'b00_1_11_0_0, fix(b[7:0]));                  // R7 clock trail
    idle_pat = k ? 7'b00_1_11_0_0 : 7'b11_0_11_0_0;
    push(idle_pat, fix(a[7:0]));                                // R5 exit
    @(negedge clk);
    cfg_w0 = a; cfg_w1 = b; cfg_w2 = c; burst_len = n; keep_clk = k; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    for (int s = 0; s < nseg; s++) begin
      bit bad = 1'b0;
      logic [6:0] got = '0;
      for (int i = 0; i < seg_len[s]; i++) begin
        if (mutate && cyc == 3) begin   // R8, R9
          cfg_w0 = 32'h0; cfg_w1 = 32'hFFFFFFFF; cfg_w2 = 32'h0;
          burst_len = 16'd40; keep_clk = ~k; req = 1'b1;
        end
        if (mutate && cyc == 6) req = 1'b0;
        if (!bad && (obs() !== seg_pat[s] || ready !== 1'b0)) begin
          bad = 1'b1;
          got = obs();
        end
        cyc++;
        @(negedge clk);
      end
      checks++;
      if (bad) begin
        errors++;
        $display("FAIL %s seg %0d (R2/R4/R5/R6/R7/R8): lines %b expected %b with ready 0",
                 tag, s, got, seg_pat[s]);
      end
    end
    checks++;
    if (ready !== 1'b1 || obs() !== idle_pat) begin
      errors++;
      $display("FAIL %s end (R5/R7): ready %b lines %b expected 1 %b", tag, ready, obs(), idle_pat);
    end
    clk_on_tb = k;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;  // R1
    if (ready !== 1'b1 || obs() !== 7'b11_0_11_0_0) begin
      errors++;
      $display("FAIL R1: ready %b lines %b expected 1 %b", ready, obs(), 7'b11_0_11_0_0);
    end

    for (int v = 0; v < 4; v++)
      run(VEC[v][112:81], VEC[v][80:49], VEC[v][48:17], VEC[v][16:1], VEC[v][0],
          $sformatf("vec%0d", v), 1'b0);

    run(32'h0, 32'h0, 32'h0, 16'd0, 1'b0, "zero_fields_R6", 1'b0);
    run(32'h00000403, 32'h02050302, 32'h00020404, 16'd6, 1'b0, "midrun_change_R8_R9", 1'b1);
    run(32'h00000101, 32'h01010101, 32'h00010101, 16'd2, 1'b1, "keep_on_R7", 1'b0);
    run(32'h00000101, 32'h01010101, 32'h00010101, 16'd2, 1'b1, "skip_clk_seq_R7", 1'b0);
    run(32'h00000201, 32'h01020102, 32'h00010201, 16'd1, 1'b0, "clk_trail_R7", 1'b0);

    repeat (4) @(negedge clk);
    checks++;  // R9: no stray transfer after idle
    if (ready !== 1'b1 || obs() !== 7'b11_0_11_0_0) begin
      errors++;
      $display("FAIL R9: ready %b lines %b expected 1 %b", ready, obs(), 7'b11_0_11_0_0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule